// File: doc/BRIEF.md
# Scalar Floating-Point Lane Divider

This block divides the lowest floating-point element of a 128-bit source register by the lowest element of a second operand. The quotient is rounded and merged into the low element of a 128-bit destination, which is taken from the first source. The width of the element is set by two parameters. The default is binary32, and the binary64 layout works the same way. A 16-bit status word comes in with each operation and carries the rounding mode, the flush-to-zero control and the denormals-are-zero control. The block returns the same word with the six sticky exception flags ORed into it.

A pulse on `start` while the block is idle captures every input. Operands that resolve without arithmetic take a short path: NaN, infinity, zero, and the treatment of denormals when denormals-are-zero is set. All other operands go through a restoring divider that produces one quotient bit per clock. It produces significand width + 2 bits, so that guard and sticky information survives. A one-cycle `done` pulse marks a new result. The result and the status stay unchanged until the next completion.

Top module: `fp_lane_div`

## Requirements
- R1: Bits W-1:0 of `result` hold the quotient (W = 1+EXP_W+MAN_W). Bits 127:W equal bits 127:W of the `src_a` captured at start.
- R2: Status word layout: bits 5:0 are flags (bit0 invalid, bit1 denormal, bit2 divide-by-zero, bit3 overflow, bit4 underflow, bit5 inexact), bit6 is denormals-are-zero, bits 12:7 are masks, bits 14:13 are the rounding mode, and bit15 is flush-to-zero. `status_out` equals the captured `status_in` with the new flags ORed into bits 5:0.
- R3: The invalid flag is set when either operand is a signalling NaN, for 0/0 and for inf/inf. 0/0 and inf/inf return the default NaN (sign 1, all-ones exponent, top fraction bit 1). A NaN operand returns the first NaN operand with its top fraction bit set.
- R4: A finite non-zero value divided by zero sets the divide-by-zero flag and returns an infinity with the XOR of the signs. inf/finite gives a signed infinity and finite/inf gives a signed zero, both without flags.
- R5: With bit6 clear, a denormal operand sets the denormal flag unless an operand is a NaN. With bit6 set, denormal operands act as signed zero and set no denormal flag.
- R6: Rounding mode 00 is nearest-even, 01 rounds toward minus infinity, 10 rounds toward plus infinity and 11 rounds toward zero.
- R7: When the rounded exponent would reach all ones, the overflow and inexact flags are set. The result is infinity, or the largest finite value when the mode rounds toward zero or away from that infinity's sign.
- R8: A quotient below the smallest normal value before rounding is returned as a denormal. It sets underflow only if it is also inexact.
- R9: With bit15 set, a quotient below the smallest normal value before rounding becomes a signed zero and sets both underflow and inexact.
- R10: The inexact flag is set whenever the delivered quotient differs from the exact one.
- R11: A start is accepted only while `busy` is low and is ignored otherwise. `done` rises one edge after the accepting edge on the short path and NQ+1 edges after it on the divide path (NQ = MAN_W+3). `done` lasts one cycle, `busy` is high until `done`, and the outputs hold between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division (accepted while idle) |
| src_a | input | 128 | Dividend register; low element is the dividend, upper bits pass through |
| src_b | input | EXP_W+MAN_W+1 | Divisor element |
| status_in | input | 16 | Control and sticky flag word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Merged destination register |
| status_out | output | 16 | Status word with the new flags merged |

## Verification
The bound checker watches the properties that hold on every cycle. These are the pass-through of the upper destination bits and of the control fields, the sticky character of the flags, the single-cycle `done` that ends `busy`, and outputs that hold between completions. Numeric behaviour is visible only through the bench's scenarios, which compare each result against hand-derived IEEE values: the rounding direction under each mode, NaN propagation, the divide-by-zero and invalid cases, overflow saturation, denormal results, flush-to-zero and denormals-are-zero. The bench also counts cycles against its own latency model and proves that a start raised during a divide is ignored.

// File: rtl/fp_lane_div.sv
module fp_lane_div #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [127:0]           src_a,
  input  logic [EXP_W+MAN_W:0]   src_b,
  input  logic [15:0]            status_in,
  output logic                   busy,
  output logic                   done,
  output logic [127:0]           result,
  output logic [15:0]            status_out
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int M  = MAN_W + 1;
  localparam int NQ = M + 2;
  localparam int XW = EXP_W + 3;
  localparam int CW = $clog2(NQ + 1);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [W-1:0] QNAN = {1'b1, EMAX, 1'b1, {(MAN_W-1){1'b0}}};

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;

  function automatic logic [XW+M-1:0] norm(input logic [EXP_W-1:0] ef, input logic [MAN_W-1:0] f);
    logic [XW-1:0] e;
    logic [M-1:0]  s;
    if (ef != '0) begin
      e = XW'(ef);
      s = {1'b1, f};
    end else begin
      e = XW'(1);
      s = {1'b0, f};
      for (int i = 0; i < MAN_W; i++)
        if (!s[M-1]) begin
          s = s << 1;
          e = e - XW'(1);
        end
    end
    return {e, s};
  endfunction

  wire [W-1:0] a = src_a[W-1:0];
  wire [W-1:0] b = src_b;
  wire daz = status_in[6];
  wire [EXP_W-1:0] ea = a[W-2:MAN_W], eb = b[W-2:MAN_W];
  wire [MAN_W-1:0] fa = a[MAN_W-1:0], fb = b[MAN_W-1:0];
  wire a_den = ea == '0 && fa != '0, b_den = eb == '0 && fb != '0;
  wire a_z = (ea == '0 && fa == '0) || (a_den && daz);
  wire b_z = (eb == '0 && fb == '0) || (b_den && daz);
  wire a_inf = ea == EMAX && fa == '0, b_inf = eb == EMAX && fb == '0;
  wire a_nan = ea == EMAX && fa != '0, b_nan = eb == EMAX && fb != '0;
  wire a_snan = a_nan && !fa[MAN_W-1], b_snan = b_nan && !fb[MAN_W-1];
  wire sgn = a[W-1] ^ b[W-1];
  wire den_flag = !daz && (a_den || b_den) && !(a_nan || b_nan);

  logic spec;
  logic [W-1:0] sres;
  logic [5:0] sflg;
  always_comb begin
    spec = 1'b1;
    sres = '0;
    sflg = {4'b0, den_flag, 1'b0};
    if (a_nan || b_nan) begin
      sflg[0] = a_snan || b_snan;
      sres = (a_nan ? a : b) | (W'(1) << (MAN_W - 1));
    end else if ((a_z && b_z) || (a_inf && b_inf)) begin
      sflg[0] = 1'b1;
      sres = QNAN;
    end else if (a_inf) sres = {sgn, EMAX, {MAN_W{1'b0}}};
    else if (b_inf) sres = {sgn, {(W-1){1'b0}}};
    else if (b_z) begin
      sflg[2] = 1'b1;
      sres = {sgn, EMAX, {MAN_W{1'b0}}};
    end else if (a_z) sres = {sgn, {(W-1){1'b0}}};
    else spec = 1'b0;
  end

  logic [XW-1:0] ea_n, eb_n;
  logic [M-1:0] ma_n, mb_n;
  assign {ea_n, ma_n} = norm(ea, fa);
  assign {eb_n, mb_n} = norm(eb, fb);

  st_t st;
  logic [CW-1:0] cnt;
  logic [M:0] rem;
  logic [M-1:0] dvs;
  logic [NQ-1:0] quo;
  logic signed [XW-1:0] e_r;
  logic sgn_r, spec_r, ftz_r;
  logic [1:0] rc_r;
  logic [W-1:0] sres_r;
  logic [5:0] flg_r;
  logic [127:W] hi_r;
  logic [15:0] stat_r;

  wire ge = rem >= {1'b0, dvs};
  wire [M:0] nrem = ge ? rem - {1'b0, dvs} : rem;

  logic top, g, s, tiny, inc, ovf, big;
  logic [M-1:0] sig;
  logic [M+1:0] shv, lostv;
  logic [EXP_W-1:0] expf;
  logic [W-2:0] rnd;
  logic [W-1:0] nres;
  logic [5:0] nflg;
  int ebi, shi;
  always_comb begin
    top  = quo[NQ-1];
    sig  = top ? quo[NQ-1 -: M] : quo[NQ-2 -: M];
    ebi  = int'(e_r) - (top ? 0 : 1);
    tiny = ebi < 1;
    shi  = tiny ? ((1 - ebi) > NQ ? NQ : 1 - ebi) : 0;
    {shv, lostv} = {sig, top ? quo[1] : quo[0], (top & quo[0]) | (|rem), {(M+2){1'b0}}} >> shi;
    g    = shv[1];
    s    = shv[0] | (|lostv);
    expf = tiny ? '0 : EXP_W'(ebi - 1);
    case (rc_r)
      2'b00:   inc = g & (s | shv[2]);
      2'b01:   inc = sgn_r & (g | s);
      2'b10:   inc = !sgn_r & (g | s);
      default: inc = 1'b0;
    endcase
    rnd  = {expf, {MAN_W{1'b0}}} + (W-1)'(shv[M+1:2]) + (W-1)'(inc);
    ovf  = (!tiny && ebi >= int'(EMAX)) || rnd[W-2:MAN_W] == EMAX;
    big  = rc_r == 2'b11 || (rc_r == 2'b01 && !sgn_r) || (rc_r == 2'b10 && sgn_r);
    nflg = flg_r;
    if (ovf) begin
      nres = big ? {sgn_r, EMAX - EXP_W'(1), {MAN_W{1'b1}}} : {sgn_r, EMAX, {MAN_W{1'b0}}};
      nflg[3] = 1'b1;
      nflg[5] = 1'b1;
    end else if (tiny && ftz_r) begin
      nres = {sgn_r, {(W-1){1'b0}}};
      nflg[4] = 1'b1;
      nflg[5] = 1'b1;
    end else begin
      nres = {sgn_r, rnd};
      nflg[4] = tiny & (g | s);
      nflg[5] = g | s;
    end
  end

  assign busy = st != IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; rem <= '0; dvs <= '0; quo <= '0; e_r <= '0;
      sgn_r <= 1'b0; spec_r <= 1'b0; ftz_r <= 1'b0; rc_r <= 2'b0; sres_r <= '0;
      flg_r <= '0; hi_r <= '0; stat_r <= '0; done <= 1'b0; result <= '0; status_out <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st     <= spec ? FIN : RUN;
          cnt    <= CW'(NQ);
          rem    <= {1'b0, ma_n};
          dvs    <= mb_n;
          quo    <= '0;
          e_r    <= ea_n - eb_n + XW'(BIAS);
          sgn_r  <= sgn;
          spec_r <= spec;
          sres_r <= sres;
          flg_r  <= sflg;
          ftz_r  <= status_in[15];
          rc_r   <= status_in[14:13];
          hi_r   <= src_a[127:W];
          stat_r <= status_in;
        end
        RUN: begin
          rem <= nrem << 1;
          quo <= {quo[NQ-2:0], ge};
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) st <= FIN;
        end
        default: begin
          st         <= IDLE;
          done       <= 1'b1;
          result     <= {hi_r, spec_r ? sres_r : nres};
          status_out <= {stat_r[15:6], stat_r[5:0] | (spec_r ? flg_r : nflg)};
        end
      endcase
    end
  end
endmodule

// File: rtl/fp_lane_div_chk.sv
module fp_lane_div_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:W] a_hi,
  input logic [15:0]  status_in,
  input logic [127:0] result,
  input logic [15:0]  status_out
);
  logic [127:W] hi_q;
  logic [15:0]  st_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_q <= '0;
      st_q <= '0;
    end else if (start && !busy) begin
      hi_q <= a_hi;
      st_q <= status_in;
    end

  assert_upper_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result[127:W] == hi_q);
  assert_ctrl_passed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status_out[15:6] == st_q[15:6]);
  assert_flags_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status_out[5:0] & st_q[5:0]) == st_q[5:0]);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_outputs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(status_out)));
  assert_busy_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind fp_lane_div fp_lane_div_chk #(.W(EXP_W+MAN_W+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .a_hi(src_a[127:EXP_W+MAN_W+1]), .status_in(status_in),
  .result(result), .status_out(status_out)
);

// File: tb/fp_lane_div_test.sv
`timescale 1ns/1ps
module fp_lane_div_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [127:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] status_in = '0;
  logic busy, done;
  logic [127:0] result;
  logic [15:0] status_out;
  int checks = 0, fails = 0, cyc = 0, tnum = 0;

  always #4 clk = ~clk;

  fp_lane_div uut (.clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
    .status_in(status_in), .busy(busy), .done(done), .result(result), .status_out(status_out));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog R11: actual cycles %0d expected < 20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [15:0] sw(input logic [1:0] rc, input bit daz, input bit ftz, input logic [5:0] fl);
    return {ftz, rc, 6'b101010, daz, fl};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // latency model: accepting edge -> done after lat edges; stray start mid-run is ignored (R11)
  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [15:0] st,
                     input logic [31:0] er, input logic [5:0] ef, input int lat,
                     input string tag, input bit poke = 1'b0);
    logic [95:0] hi;
    int n;
    bit busy_ok = 1'b1;
    tnum++;
    hi = {3{32'h9E3779B9 ^ 32'(tnum * 7919)}};
    @(negedge clk);
    src_a = {hi, a}; src_b = b; status_in = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    src_a = {~hi, 32'h3F800000}; src_b = 32'h40000000; status_in = 16'h0;
    n = 1;
    while (!done && n < 200) begin
      if (!busy) busy_ok = 1'b0;
      if (poke && n == 3) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk(busy_ok && !busy, {tag, " R11 busy"}, 128'(busy), 128'(1));
    chk(n == lat + 1, {tag, " R11 latency"}, 128'(n - 1), 128'(lat));
    chk(result[31:0] == er, {tag, " result"}, 128'(result[31:0]), 128'(er));
    chk(result[127:32] == hi, {tag, " R1 upper"}, 128'(result[127:32]), 128'(hi));
    chk(status_out == {st[15:6], st[5:0] | ef}, {tag, " R2 status"}, 128'(status_out),
        128'({st[15:6], st[5:0] | ef}));
    @(negedge clk);
    chk(!done && !busy, {tag, " R11 done pulse"}, 128'({done, busy}), 128'(0));
  endtask

  localparam int DIV = 27;
  localparam int SPC = 1;

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == '0 && status_out == '0, "R11 reset", 128'({busy, done}), 128'(0));
    rst_n = 1'b1;
    run(32'h40C00000, 32'h40000000, sw(2'b00, 0, 0, 6'h00), 32'h40400000, 6'h00, DIV, "R1 6/2");
    run(32'h3F800000, 32'h40400000, sw(2'b00, 0, 0, 6'h00), 32'h3EAAAAAB, 6'h20, DIV, "R10 R6 1/3 nearest");
    run(32'h3F800000, 32'h40400000, sw(2'b11, 0, 0, 6'h00), 32'h3EAAAAAA, 6'h20, DIV, "R6 1/3 to zero");
    run(32'hBF800000, 32'h40400000, sw(2'b01, 0, 0, 6'h00), 32'hBEAAAAAB, 6'h20, DIV, "R6 -1/3 down");
    run(32'hBF800000, 32'h40400000, sw(2'b10, 0, 0, 6'h00), 32'hBEAAAAAA, 6'h20, DIV, "R6 -1/3 up");
    run(32'h3F800000, 32'h00000000, sw(2'b00, 0, 0, 6'h00), 32'h7F800000, 6'h04, SPC, "R4 1/0");
    run(32'hC0000000, 32'h80000000, sw(2'b00, 0, 0, 6'h00), 32'h7F800000, 6'h04, SPC, "R4 -2/-0");
    run(32'h00000000, 32'h80000000, sw(2'b00, 0, 0, 6'h00), 32'hFFC00000, 6'h01, SPC, "R3 0/0");
    run(32'h7F800000, 32'hFF800000, sw(2'b00, 0, 0, 6'h00), 32'hFFC00000, 6'h01, SPC, "R3 inf/inf");
    run(32'h7F800001, 32'h3F800000, sw(2'b00, 0, 0, 6'h00), 32'h7FC00001, 6'h01, SPC, "R3 snan/1");
    run(32'h3F800000, 32'hFFC00005, sw(2'b00, 0, 0, 6'h00), 32'hFFC00005, 6'h00, SPC, "R3 1/qnan");
    run(32'h7F800000, 32'hC0000000, sw(2'b00, 0, 0, 6'h00), 32'hFF800000, 6'h00, SPC, "R4 inf/-2");
    run(32'hC0000000, 32'h7F800000, sw(2'b00, 0, 0, 6'h00), 32'h80000000, 6'h00, SPC, "R4 -2/inf");
    run(32'h7F7FFFFF, 32'h3F000000, sw(2'b00, 0, 0, 6'h00), 32'h7F800000, 6'h28, DIV, "R7 ovf nearest");
    run(32'h7F7FFFFF, 32'h3F000000, sw(2'b11, 0, 0, 6'h00), 32'h7F7FFFFF, 6'h28, DIV, "R7 ovf to zero");
    run(32'hFF7FFFFF, 32'h3F000000, sw(2'b10, 0, 0, 6'h00), 32'hFF7FFFFF, 6'h28, DIV, "R7 -ovf up");
    run(32'h00800000, 32'h40800000, sw(2'b00, 0, 0, 6'h00), 32'h00200000, 6'h00, DIV, "R8 exact tiny");
    run(32'h00800000, 32'h40400000, sw(2'b00, 0, 0, 6'h00), 32'h002AAAAB, 6'h30, DIV, "R8 inexact tiny");
    run(32'h80800000, 32'h40400000, sw(2'b00, 0, 1, 6'h00), 32'h80000000, 6'h30, DIV, "R9 flush");
    run(32'h00000001, 32'h3F800000, sw(2'b00, 0, 0, 6'h00), 32'h00000001, 6'h02, DIV, "R5 denormal");
    run(32'h00000001, 32'h3F800000, sw(2'b00, 1, 0, 6'h00), 32'h00000000, 6'h00, SPC, "R5 daz");
    run(32'h40C00000, 32'h40000000, sw(2'b00, 0, 0, 6'h21), 32'h40400000, 6'h00, DIV, "R2 sticky");
    run(32'h40C00000, 32'h40000000, sw(2'b00, 0, 0, 6'h00), 32'h40400000, 6'h00, DIV, "R11 start ignored", 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule